// File: doc/BRIEF.md
# Memory Error Address Capture Register

This block records where the first uncorrectable parity or double-bit ECC error happened while a transmit buffer RAM was being read. The block does not detect errors itself. Two readers of the RAM report errors with a one-cycle pulse and the failing byte address: the host CPU port and the transfer sequencer. The block keeps the first address it accepts together with an uncorrectable-error flag. While the flag is set the stored address is frozen, and later errors are dropped.

The host reaches the block through a small register port with two registers. One is a status register with a write-one-to-clear flag bit. The other is a read-to-clear address register. Reading the address register returns the stored address and clears both the address and the flag. When the emulation-debug input is high, the same read leaves everything unchanged, so a debugger can inspect the register without disturbing it. The stored address has no reset; only reads clear it. The flag is cleared by reset.

A mode input selects the active buffer window: the normal window (0x200 to 0x3FF) or the extended window (0x400 to 0x7FF). An error report whose address lies outside the active window is not captured.

Top module: `memerr_addr_capture`

## Requirements
- R1: `host_reg` = 1 selects the address register. Reading it gives the stored address in bits 10:0, and bits 31:11 read as zero. `host_reg` = 0 selects the status register. Reading it gives the flag in bit 0, and bits 31:1 read as zero. `host_rdata` is zero when `host_rd` is low.
- R2: While the flag is clear, an accepted error pulse from either source is captured. From the next cycle the flag reads 1 and the address register holds that error's byte address.
- R3: While the flag is set, new error pulses do not change the stored address.
- R4: If both sources report an accepted error in the same cycle while the flag is clear, the sequencer's address is stored and the CPU's is dropped.
- R5: A host read of the address register with `emu_dbg` low returns the stored address. From the next cycle the address reads 0 and the flag reads 0.
- R6: A host read of the address register with `emu_dbg` high returns the stored address. Both the address and the flag are left unchanged.
- R7: Host writes to the address register have no effect.
- R8: A host write to the status register with bit 0 = 1 clears the flag, keeps the stored address and re-arms capture. A write with bit 0 = 0 has no effect.
- R9: Reset clears the flag but never alters the stored address.
- R10: With `ext_buf_en` = 0 only addresses 0x200 to 0x3FF are accepted. With `ext_buf_en` = 1 only addresses 0x400 to 0x7FF are accepted. Errors at other addresses are ignored.
- R11: While the flag is clear, an error in the same cycle as a clearing address read is still captured; the capture takes precedence over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_buf_en | input | 1 | Selects the extended buffer window |
| emu_dbg | input | 1 | Emulation mode: host reads have no side effects |
| cpu_err_vld | input | 1 | Error pulse from the CPU read path |
| cpu_err_addr | input | 11 | Failing byte address from the CPU read path |
| seq_err_vld | input | 1 | Error pulse from the sequencer read path |
| seq_err_addr | input | 11 | Failing byte address from the sequencer read path |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_reg | input | 1 | Register select: 0 status, 1 address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, valid in the cycle of `host_rd` |

## Verification
On every cycle the assertions check four things. The address stays frozen while the flag is set. A capture loads the offered address and sets the flag. A clearing read zeroes both the address and the flag, while an emulation read leaves both unchanged. A flag write-one-to-clear keeps the address. Some behaviours can only be shown by the bench's scenarios, which look at the ports: sequencer priority on a same-cycle collision, rejection of addresses outside the window in each mode, writes to the address register being ignored, the address surviving a reset, and capture winning over a simultaneous clear.

// File: rtl/memerr_pkg.sv
package memerr_pkg;
  typedef enum logic {
    REG_STAT = 1'b0,
    REG_ADDR = 1'b1
  } memerr_reg_e;
endpackage

// File: rtl/memerr_src_arb.sv
module memerr_src_arb #(
  parameter int ADDR_W = 11
) (
  input  logic              ext_buf_en,
  input  logic              cpu_vld,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              seq_vld,
  input  logic [ADDR_W-1:0] seq_addr,
  output logic              cap_vld,
  output logic [ADDR_W-1:0] cap_addr
);
  // Normal window: top bit 0, next bit 1. Extended window: top bit 1.
  function automatic logic in_window(input logic [ADDR_W-1:0] a, input logic ext);
    if (ext) return a[ADDR_W-1];
    else     return !a[ADDR_W-1] && a[ADDR_W-2];
  endfunction

  logic cpu_ok, seq_ok;

  always_comb begin
    cpu_ok   = cpu_vld && in_window(cpu_addr, ext_buf_en);
    seq_ok   = seq_vld && in_window(seq_addr, ext_buf_en);
    cap_vld  = cpu_ok || seq_ok;
    cap_addr = seq_ok ? seq_addr : cpu_addr;  // sequencer has priority
  end
endmodule

// File: rtl/memerr_capture_reg.sv
module memerr_capture_reg #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_vld,
  input  logic [ADDR_W-1:0] cap_addr,
  input  logic              rd_clr,
  input  logic              w1c,
  output logic              flag_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic              flag_q, flag_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              addr_en;

  always_comb begin
    flag_d  = flag_q;
    addr_d  = addr_q;
    addr_en = 1'b0;
    if (!flag_q && cap_vld) begin
      flag_d  = 1'b1;
      addr_d  = cap_addr;
      addr_en = 1'b1;
    end else if (rd_clr) begin
      flag_d  = 1'b0;
      addr_d  = '0;
      addr_en = 1'b1;
    end else if (w1c) begin
      flag_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  // No reset on purpose: the address survives every reset.
  always_ff @(posedge clk) begin
    if (addr_en) addr_q <= addr_d;
  end

  assign flag_o = flag_q;
  assign addr_o = addr_q;

  assert_freeze_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !rd_clr) |=> $stable(addr_q));
  assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_q && cap_vld) |=> (flag_q && addr_q == $past(cap_addr)));
  assert_rdclr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && rd_clr) |=> (!flag_q && addr_q == '0));
  assert_w1c_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && w1c && !rd_clr) |=> (!flag_q && $stable(addr_q)));
endmodule

// File: rtl/memerr_host_if.sv
module memerr_host_if
  import memerr_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 32
) (
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic              host_reg,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              emu_dbg,
  input  logic              flag,
  input  logic [ADDR_W-1:0] addr,
  output logic              rd_clr,
  output logic              w1c,
  output logic [DATA_W-1:0] host_rdata
);
  localparam int PAD_W = DATA_W - ADDR_W;

  logic sel_addr;

  always_comb begin
    sel_addr = (memerr_reg_e'(host_reg) == REG_ADDR);
    rd_clr   = host_rd && sel_addr && !emu_dbg;
    w1c      = host_wr && !sel_addr && host_wdata[0];
    if (!host_rd)      host_rdata = '0;
    else if (sel_addr) host_rdata = {{PAD_W{1'b0}}, addr};
    else               host_rdata = {{(DATA_W-1){1'b0}}, flag};
  end
endmodule

// File: rtl/memerr_addr_capture.sv
module memerr_addr_capture #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_buf_en,
  input  logic              emu_dbg,
  input  logic              cpu_err_vld,
  input  logic [ADDR_W-1:0] cpu_err_addr,
  input  logic              seq_err_vld,
  input  logic [ADDR_W-1:0] seq_err_addr,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic              host_reg,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              cap_vld, rd_clr, w1c, flag;
  logic [ADDR_W-1:0] cap_addr, addr;

  // Assert asynchronously, release on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  memerr_src_arb #(.ADDR_W(ADDR_W)) u_arb (
    .ext_buf_en (ext_buf_en),
    .cpu_vld    (cpu_err_vld),
    .cpu_addr   (cpu_err_addr),
    .seq_vld    (seq_err_vld),
    .seq_addr   (seq_err_addr),
    .cap_vld    (cap_vld),
    .cap_addr   (cap_addr)
  );

  memerr_capture_reg #(.ADDR_W(ADDR_W)) u_cap (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .cap_vld  (cap_vld),
    .cap_addr (cap_addr),
    .rd_clr   (rd_clr),
    .w1c      (w1c),
    .flag_o   (flag),
    .addr_o   (addr)
  );

  memerr_host_if #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_host (
    .host_rd    (host_rd),
    .host_wr    (host_wr),
    .host_reg   (host_reg),
    .host_wdata (host_wdata),
    .emu_dbg    (emu_dbg),
    .flag       (flag),
    .addr       (addr),
    .rd_clr     (rd_clr),
    .w1c        (w1c),
    .host_rdata (host_rdata)
  );

  assert_emu_hold_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (flag && host_rd && host_reg && emu_dbg && !host_wr) |=> (flag && $stable(addr)));
endmodule

// File: tb/memerr_addr_capture_bench.sv
module memerr_addr_capture_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ext_buf_en, emu_dbg;
  logic        cpu_err_vld, seq_err_vld;
  logic [10:0] cpu_err_addr, seq_err_addr;
  logic        host_rd, host_wr, host_reg;
  logic [31:0] host_wdata, host_rdata;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  memerr_addr_capture u_memerr_addr_capture (
    .clk(clk), .rst_n(rst_n), .ext_buf_en(ext_buf_en), .emu_dbg(emu_dbg),
    .cpu_err_vld(cpu_err_vld), .cpu_err_addr(cpu_err_addr),
    .seq_err_vld(seq_err_vld), .seq_err_addr(seq_err_addr),
    .host_rd(host_rd), .host_wr(host_wr), .host_reg(host_reg),
    .host_wdata(host_wdata), .host_rdata(host_rdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic err(input logic cv, input logic [10:0] ca, input logic sv, input logic [10:0] sa);
    @(negedge clk);
    cpu_err_vld = cv; cpu_err_addr = ca; seq_err_vld = sv; seq_err_addr = sa;
    @(negedge clk);
    cpu_err_vld = 1'b0; seq_err_vld = 1'b0;
  endtask

  task automatic rd(input logic r, input logic emu, output logic [31:0] d);
    @(negedge clk);
    host_rd = 1'b1; host_reg = r; emu_dbg = emu;
    #1 d = host_rdata;
    @(negedge clk);
    host_rd = 1'b0; emu_dbg = 1'b0;
  endtask

  task automatic wr(input logic r, input logic [31:0] v);
    @(negedge clk);
    host_wr = 1'b1; host_reg = r; host_wdata = v;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  function automatic logic [31:0] dummy(input logic [31:0] x); return x; endfunction

  task automatic peek_addr(output logic [31:0] d); rd(1'b1, 1'b1, d); endtask
  task automatic peek_stat(output logic [31:0] d); rd(1'b0, 1'b0, d); endtask
  task automatic clear_all(); logic [31:0] d; rd(1'b1, 1'b0, d); endtask

  task automatic t_reset_state();
    logic [31:0] d;
    peek_stat(d); chk("R9 flag after reset", d, 32'h0);
    clear_all();
    peek_addr(d); chk("R5 address after clearing read", d, 32'h0);
    @(negedge clk); #1 chk("R1 rdata idle", host_rdata, 32'h0);
  endtask

  task automatic t_cpu_capture_and_freeze();
    logic [31:0] d;
    ext_buf_en = 1'b0;
    err(1'b1, 11'h234, 1'b0, 11'h0);
    peek_stat(d); chk("R2 flag after cpu error", d, 32'h1);
    peek_addr(d); chk("R2/R1 cpu address", d, 32'h234);
    err(1'b0, 11'h0, 1'b1, 11'h300);
    peek_addr(d); chk("R3 frozen address", d, 32'h234);
    rd(1'b1, 1'b0, d); chk("R5 read returns address", d, 32'h234);
    peek_stat(d); chk("R5 flag cleared by read", d, 32'h0);
    peek_addr(d); chk("R5 address cleared by read", d, 32'h0);
  endtask

  task automatic t_seq_and_w1c();
    logic [31:0] d;
    err(1'b0, 11'h0, 1'b1, 11'h3fe);
    peek_addr(d); chk("R2 sequencer address", d, 32'h3fe);
    wr(1'b0, 32'hffff_fffe);
    peek_stat(d); chk("R8 write of 0 keeps flag", d, 32'h1);
    wr(1'b0, 32'h1);
    peek_stat(d); chk("R8 w1c clears flag", d, 32'h0);
    peek_addr(d); chk("R8 w1c keeps address", d, 32'h3fe);
    err(1'b1, 11'h201, 1'b0, 11'h0);
    peek_addr(d); chk("R8 capture re-armed", d, 32'h201);
    clear_all();
  endtask

  task automatic t_emu();
    logic [31:0] d;
    err(1'b1, 11'h2aa, 1'b0, 11'h0);
    rd(1'b1, 1'b1, d); chk("R6 emulation read data", d, 32'h2aa);
    peek_stat(d); chk("R6 flag kept in emulation", d, 32'h1);
    rd(1'b1, 1'b1, d); chk("R6 address kept in emulation", d, 32'h2aa);
    clear_all();
  endtask

  task automatic t_priority_and_write();
    logic [31:0] d;
    err(1'b1, 11'h210, 1'b1, 11'h220);
    peek_addr(d); chk("R4 sequencer wins", d, 32'h220);
    wr(1'b1, 32'hffff_ffff);
    peek_addr(d); chk("R7 write to address ignored", d, 32'h220);
    peek_stat(d); chk("R7 flag after address write", d, 32'h1);
    clear_all();
  endtask

  task automatic t_window();
    logic [31:0] d;
    ext_buf_en = 1'b0;
    err(1'b1, 11'h500, 1'b0, 11'h0);
    peek_stat(d); chk("R10 0x500 rejected in normal mode", d, 32'h0);
    err(1'b0, 11'h0, 1'b1, 11'h1ff);
    peek_stat(d); chk("R10 0x1FF rejected", d, 32'h0);
    err(1'b1, 11'h3ff, 1'b0, 11'h0);
    peek_addr(d); chk("R10 0x3FF accepted in normal mode", d, 32'h3ff);
    clear_all();
    ext_buf_en = 1'b1;
    err(1'b1, 11'h3ff, 1'b0, 11'h0);
    peek_stat(d); chk("R10 0x3FF rejected in extended mode", d, 32'h0);
    err(1'b1, 11'h3ff, 1'b1, 11'h400);
    peek_addr(d); chk("R10 0x400 accepted in extended mode", d, 32'h400);
    clear_all();
  endtask

  task automatic t_reset_keeps_addr();
    logic [31:0] d;
    ext_buf_en = 1'b1;
    err(1'b0, 11'h0, 1'b1, 11'h456);
    do_reset();
    peek_stat(d); chk("R9 flag cleared by reset", d, 32'h0);
    peek_addr(d); chk("R9 address survives reset", d, 32'h456);
  endtask

  task automatic t_capture_beats_clear();
    logic [31:0] d;
    clear_all();
    @(negedge clk);
    host_rd = 1'b1; host_reg = 1'b1; emu_dbg = 1'b0;
    seq_err_vld = 1'b1; seq_err_addr = 11'h7f0;
    @(negedge clk);
    host_rd = 1'b0; seq_err_vld = 1'b0;
    peek_stat(d); chk("R11 flag set despite clear", d, 32'h1);
    peek_addr(d); chk("R11 address captured", d, 32'h7f0);
  endtask

  initial begin
    rst_n = 1'b0; ext_buf_en = 1'b0; emu_dbg = 1'b0;
    cpu_err_vld = 1'b0; seq_err_vld = 1'b0; cpu_err_addr = '0; seq_err_addr = '0;
    host_rd = 1'b0; host_wr = 1'b0; host_reg = 1'b0; host_wdata = '0;
    do_reset();
    t_reset_state();
    t_cpu_capture_and_freeze();
    t_seq_and_w1c();
    t_emu();
    t_priority_and_write();
    t_window();
    t_reset_keeps_addr();
    t_capture_beats_clear();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule